// File: doc/BRIEF.md
# Differential Quadrant Constellation Mapper

This block sits between a bit scrambler and a modulator front end. Once per symbol period it takes a short group of serial bits and turns it into one constellation point, given as signed in-phase and quadrature coordinates. It has two rates. The high rate takes four bits per symbol and uses a 16-point grid. The low rate takes two bits per symbol and uses a 4-point phase-only set. The symbol period is the same at both rates.

The block requests each bit itself. For one cycle it raises `bit_req`, and the source must present the next bit on `bit_in` in that same cycle. The first two bits of each group are coded differentially: they select a quarter-turn step, and that step is added modulo 4 to the quadrant of the previous symbol. At the high rate, the next two bits pick one of four points inside the new quadrant. The points are defined for the first quadrant and rotated into place for the others. At the low rate, every symbol uses one fixed point of its quadrant. Carrier generation and pulse shaping take place downstream.

Top module: `dq_symbol_mapper`

## Requirements
- R1: `sym_vld` is high for exactly one cycle every `SYM_CYCLES` cycles. The first strobe comes in cycle `SYM_CYCLES` after reset is released, counting the first cycle with reset low as cycle 0.
- R2: In each symbol period `bit_req` is high for exactly 4 cycles at the high rate (`rate_sel`=1) and for exactly 2 cycles at the low rate (`rate_sel`=0). These are cycles 1..4 or 1..2 of the period. A bit is taken from `bit_in` in each cycle where `bit_req` is high.
- R3: Take b1 as the first bit of a group and b2 as the second. The pair b1b2 moves the quadrant forward counter-clockwise as follows: 00 by one quarter turn, 01 by none, 10 by two, 11 by three, all modulo 4.
- R4: Quadrant 1 is positive I and positive Q. In quadrant 1, the third and fourth bits b3b4 select the point (I,Q): 00 gives (1,1), 01 gives (3,1), 11 gives (3,3), 10 gives (1,3).
- R5: Quadrants 2, 3 and 4 are numbered counter-clockwise. They use the quadrant-1 point rotated by 90°, 180° and 270°, where one rotation maps (x,y) to (−y,x).
- R6: At the low rate every symbol uses the point that b3b4=01 selects in its quadrant. One coordinate then has magnitude 3 and the other magnitude 1.
- R7: During reset `sym_vld` and `bit_req` are low and `i_out`/`q_out` are 0. The quadrant state is quadrant 1, so a first group starting 01 lands in quadrant 1.
- R8: `rate_sel` is sampled only in cycle 0 of each symbol period. A change later in the period has no effect on that symbol's bit count or point.
- R9: `i_out` and `q_out` change only on the edge that raises `sym_vld` and hold their value otherwise.
- R10: While `sym_vld` is high every coordinate is ±1 or ±3, as 3-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 1 = four bits per symbol, 0 = two bits per symbol |
| bit_in | input | 1 | Serial data bit, taken when bit_req is high |
| bit_req | output | 1 | Requests a bit in the current cycle |
| sym_vld | output | 1 | One-cycle strobe marking a new point |
| i_out | output | 3 | Signed in-phase coordinate |
| q_out | output | 3 | Signed quadrature coordinate |

## Verification
The bench drives a fixed opening group after reset. This catches a quadrant state reset to the wrong value, which would rotate every point that follows. Long random streams at both rates exercise all four step codes in every quadrant. A step table with two codes swapped, or a rotation taken clockwise, would put points in a mirrored quadrant. The bench also flips `rate_sel` in the middle of a symbol. A design that sampled the rate outside the boundary would then request a wrong number of bits and shift every later group. A second reset in the middle of a run checks that the accumulated quadrant is cleared rather than carried over.

// File: rtl/dqm_pkg.sv
package dqm_pkg;

    localparam int COORD_W = 3;

    typedef logic signed [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t i;
        coord_t q;
    } point_t;

    typedef enum logic {
        RATE_LOW  = 1'b0,
        RATE_HIGH = 1'b1
    } rate_e;

    typedef logic [1:0] quad_t;

    // dibit used for every symbol at the low rate
    localparam logic [1:0] LOW_RATE_DIBIT = 2'b01;

    // quarter-turn step for the leading dibit (b1 first in time)
    function automatic quad_t quad_step(input logic b1, input logic b2);
        quad_t s;
        case ({b1, b2})
            2'b00:   s = 2'd1;
            2'b01:   s = 2'd0;
            2'b10:   s = 2'd2;
            default: s = 2'd3;
        endcase
        return s;
    endfunction

    // point inside the first quadrant for the trailing dibit
    function automatic point_t base_point(input logic [1:0] d);
        point_t p;
        case (d)
            2'b00:   begin p.i = 3'sd1; p.q = 3'sd1; end
            2'b01:   begin p.i = 3'sd3; p.q = 3'sd1; end
            2'b11:   begin p.i = 3'sd3; p.q = 3'sd3; end
            default: begin p.i = 3'sd1; p.q = 3'sd3; end
        endcase
        return p;
    endfunction

    // one counter-clockwise quarter turn
    function automatic point_t rotate_quarter(input point_t p);
        point_t r;
        r.i = -p.q;
        r.q = p.i;
        return r;
    endfunction

    function automatic point_t rotate_times(input point_t p, input int n);
        point_t r;
        r = p;
        for (int k = 0; k < 3; k++) begin
            if (k < n) r = rotate_quarter(r);
        end
        return r;
    endfunction

    // true when the coordinate has magnitude 3
    function automatic logic is_outer(input coord_t c);
        return c[2] ^ c[1];
    endfunction

endpackage

// File: rtl/dqm_symbol_timer.sv
module dqm_symbol_timer
    import dqm_pkg::*;
#(
    parameter int SYM_CYCLES = 16,
    parameter int HI_BITS    = 4,
    parameter int LO_BITS    = 2,
    localparam int CNT_W     = $clog2(SYM_CYCLES),
    localparam int IDX_W     = $clog2(HI_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_in,
    output rate_e            rate_q,
    output logic             bit_req,
    output logic [IDX_W-1:0] bit_idx,
    output logic             sym_end
);

    localparam logic [CNT_W-1:0] LAST  = CNT_W'(SYM_CYCLES - 1);
    localparam logic [CNT_W-1:0] N_HI  = CNT_W'(HI_BITS);
    localparam logic [CNT_W-1:0] N_LO  = CNT_W'(LO_BITS);
    localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rate_q <= RATE_LOW;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + FIRST;
            if (cnt == '0) rate_q <= rate_e'(rate_in);
        end
    end

    always_comb begin
        nbits   = (rate_q == RATE_HIGH) ? N_HI : N_LO;
        bit_req = (cnt >= FIRST) && (cnt <= nbits);
        bit_idx = IDX_W'(cnt - FIRST);
        sym_end = (cnt == LAST);
    end

    // R8: the rate register moves only at a symbol boundary
    assert_rate_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> $stable(rate_q));

    // R2: requests never reach the emit cycle
    assert_req_window_R2: assert property (@(posedge clk) disable iff (rst)
        bit_req |-> !sym_end);

endmodule

// File: rtl/dqm_bit_gather.sv
module dqm_bit_gather #(
    parameter int GRP_BITS = 4,
    localparam int IDX_W   = $clog2(GRP_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_req,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                bit_in,
    output logic [GRP_BITS-1:0] grp
);

    // grp[0] holds the earliest bit of the group
    for (genvar g = 0; g < GRP_BITS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                grp[g] <= 1'b0;
            end else if (bit_req && bit_idx == IDX_W'(g)) begin
                grp[g] <= bit_in;
            end
        end
    end

endmodule

// File: rtl/dqm_point_rotator.sv
module dqm_point_rotator
    import dqm_pkg::*;
(
    input  logic [1:0] dibit,
    input  quad_t      quad,
    output point_t     pt
);

    point_t base;
    point_t turned [4];

    assign base = base_point(dibit);

    for (genvar k = 0; k < 4; k++) begin : g_turn
        assign turned[k] = rotate_times(base, k);
    end

    assign pt = turned[quad];

endmodule

// File: rtl/dqm_quadrant_acc.sv
module dqm_quadrant_acc
    import dqm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_end,
    input  rate_e      rate_q,
    input  logic [3:0] grp,
    output logic       sym_vld,
    output point_t     pt_q
);

    quad_t      quad;
    quad_t      quad_nx;
    logic [1:0] dibit;
    point_t     pt_nx;

    always_comb begin
        quad_nx = quad + quad_step(grp[0], grp[1]);
        dibit   = (rate_q == RATE_HIGH) ? {grp[2], grp[3]} : LOW_RATE_DIBIT;
    end

    dqm_point_rotator u_rot (
        .dibit (dibit),
        .quad  (quad_nx),
        .pt    (pt_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            quad    <= 2'd0;
            pt_q    <= '0;
            sym_vld <= 1'b0;
        end else begin
            sym_vld <= sym_end;
            if (sym_end) begin
                quad <= quad_nx;
                pt_q <= pt_nx;
            end
        end
    end

    // R1: the strobe lasts a single cycle
    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        sym_vld |=> !sym_vld);

    // R9: coordinates hold between strobes
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !sym_vld |-> ($stable(pt_q.i) && $stable(pt_q.q)));

    // R10: coordinates on the strobe are odd
    assert_odd_coord_R10: assert property (@(posedge clk) disable iff (rst)
        sym_vld |-> (pt_q.i[0] && pt_q.q[0]));

    // R6: low-rate points mix one inner and one outer coordinate
    assert_low_rate_point_R6: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && rate_q == RATE_LOW) |-> (is_outer(pt_q.i) != is_outer(pt_q.q)));

endmodule

// File: rtl/dq_symbol_mapper.sv
module dq_symbol_mapper
    import dqm_pkg::*;
#(
    parameter int SYM_CYCLES = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rate_sel,
    input  logic                      bit_in,
    output logic                      bit_req,
    output logic                      sym_vld,
    output logic signed [COORD_W-1:0] i_out,
    output logic signed [COORD_W-1:0] q_out
);

    localparam int HI_BITS = 4;
    localparam int LO_BITS = 2;
    localparam int IDX_W   = $clog2(HI_BITS);

    rate_e              rate_q;
    logic [IDX_W-1:0]   bit_idx;
    logic               sym_end;
    logic [HI_BITS-1:0] grp;
    point_t             pt_q;

    dqm_symbol_timer #(
        .SYM_CYCLES (SYM_CYCLES),
        .HI_BITS    (HI_BITS),
        .LO_BITS    (LO_BITS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .rate_in (rate_sel),
        .rate_q  (rate_q),
        .bit_req (bit_req),
        .bit_idx (bit_idx),
        .sym_end (sym_end)
    );

    dqm_bit_gather #(
        .GRP_BITS (HI_BITS)
    ) u_gather (
        .clk     (clk),
        .rst     (rst),
        .bit_req (bit_req),
        .bit_idx (bit_idx),
        .bit_in  (bit_in),
        .grp     (grp)
    );

    dqm_quadrant_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .sym_end (sym_end),
        .rate_q  (rate_q),
        .grp     (grp),
        .sym_vld (sym_vld),
        .pt_q    (pt_q)
    );

    assign i_out = pt_q.i;
    assign q_out = pt_q.q;

endmodule

// File: tb/dq_symbol_mapper_test.sv
module dq_symbol_mapper_test;

    localparam int CLK_PERIOD = 10;
    localparam int SYM        = 16;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_sel = 1'b0;
    logic bit_in = 1'b0;
    logic bit_req;
    logic sym_vld;
    logic signed [2:0] i_out;
    logic signed [2:0] q_out;

    dq_symbol_mapper #(.SYM_CYCLES(SYM)) uut (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .bit_in   (bit_in),
        .bit_req  (bit_req),
        .sym_vld  (sym_vld),
        .i_out    (i_out),
        .q_out    (q_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int exp_i[$];
    int exp_q[$];
    bit forced[$];

    int model_quad = 0;
    bit model_rate = 1'b0;
    bit grp_bits [4];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        end
    endtask

    // reference: R3 step, R4 base point, R5 rotation, R6 fixed dibit
    task automatic model_emit();
        int inc, x, y, ei, eq;
        logic [1:0] d;
        case ({grp_bits[0], grp_bits[1]})
            2'b00:   inc = 1;
            2'b01:   inc = 0;
            2'b10:   inc = 2;
            default: inc = 3;
        endcase
        model_quad = (model_quad + inc) % 4;
        d = model_rate ? {grp_bits[2], grp_bits[3]} : 2'b01;
        case (d)
            2'b00:   begin x = 1; y = 1; end
            2'b01:   begin x = 3; y = 1; end
            2'b11:   begin x = 3; y = 3; end
            default: begin x = 1; y = 3; end
        endcase
        case (model_quad)
            0:       begin ei = x;  eq = y;  end
            1:       begin ei = -y; eq = x;  end
            2:       begin ei = -x; eq = -y; end
            default: begin ei = y;  eq = -x; end
        endcase
        exp_i.push_back(ei);
        exp_q.push_back(eq);
    endtask

    // monitor: scoreboard compare on each strobe (R3, R4, R5, R6, R10)
    always @(negedge clk) begin
        if (sym_vld) begin
            if (exp_i.size() == 0) begin
                check(1'b0, "R1", "unexpected strobe", 1, 0);
            end else begin
                int ei, eq;
                ei = exp_i.pop_front();
                eq = exp_q.pop_front();
                check(int'(i_out) == ei, "R5", "i_out", int'(i_out), ei);
                check(int'(q_out) == eq, "R5", "q_out", int'(q_out), eq);
            end
        end
    end

    // one symbol period; mid_flip toggles rate_sel inside the period (R8)
    task automatic run_symbol(input bit rate, input bit mid_flip);
        int nreq;
        nreq = 0;
        for (int c = 0; c < SYM; c++) begin
            if (c == 0) begin
                rate_sel   = rate;
                model_rate = rate;
            end
            if (mid_flip && c == 3) rate_sel = ~rate;
            if (bit_req) begin
                bit b;
                if (forced.size() > 0) b = forced.pop_front();
                else b = 1'($urandom_range(0, 1));
                bit_in = b;
                if (nreq < 4) grp_bits[nreq] = b;
                nreq++;
            end else begin
                bit_in = 1'($urandom_range(0, 1));
            end
            if (c == SYM - 1) begin
                check(nreq == (model_rate ? 4 : 2), mid_flip ? "R8" : "R2",
                      "bit_req count", nreq, model_rate ? 4 : 2);
                model_emit();
            end
            @(negedge clk);
        end
    endtask

    // reset, then release at a negedge that begins cycle 0 (R7)
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(sym_vld == 1'b0, "R7", "sym_vld in reset", int'(sym_vld), 0);
        check(bit_req == 1'b0, "R7", "bit_req in reset", int'(bit_req), 0);
        check(i_out == 3'sd0, "R7", "i_out in reset", int'(i_out), 0);
        check(q_out == 3'sd0, "R7", "q_out in reset", int'(q_out), 0);
        model_quad = 0;
        exp_i.delete();
        exp_q.delete();
        rst = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R7: first group 01 keeps quadrant 1; b3b4=01 gives (3,1) (R4)
        forced.push_back(1'b0); forced.push_back(1'b1);
        forced.push_back(1'b0); forced.push_back(1'b1);
        // R3: 00 steps to quadrant 2; R5: (3,3) becomes (-3,3)
        forced.push_back(1'b0); forced.push_back(1'b0);
        forced.push_back(1'b1); forced.push_back(1'b1);
        // R3: 11 steps three quarters back to quadrant 1; R4: 10 gives (1,3)
        forced.push_back(1'b1); forced.push_back(1'b1);
        forced.push_back(1'b1); forced.push_back(1'b0);
        run_symbol(1'b1, 1'b0);
        run_symbol(1'b1, 1'b0);
        run_symbol(1'b1, 1'b0);
        // R1: strobe cadence and high-rate random traffic
        for (int n = 0; n < 40; n++) run_symbol(1'b1, 1'b0);
        // R6: low-rate random traffic
        for (int n = 0; n < 40; n++) run_symbol(1'b0, 1'b0);
        // R8: rate flips in mid-period
        for (int n = 0; n < 40; n++) run_symbol(1'($urandom_range(0, 1)), 1'b1);
        // R7: reset clears the accumulated quadrant
        do_reset();
        forced.push_back(1'b0); forced.push_back(1'b1);
        forced.push_back(1'b1); forced.push_back(1'b1);
        run_symbol(1'b1, 1'b0);
        for (int n = 0; n < 10; n++) run_symbol(1'($urandom_range(0, 1)), 1'b0);
        @(negedge clk);
        @(negedge clk);
        check(exp_i.size() == 0, "R1", "pending strobes", exp_i.size(), 0);
        summary();
        $finish;
    end

endmodule